// File: doc/BRIEF.md
# Byte-Indirect Bus Master Bridge

This block gives a host with only a narrow byte register port a way to issue full-width transactions on a system bus. The host writes a target address into four byte registers. It writes outgoing data into four more and picks an access width in a size register. It then launches one transfer. A write is launched by storing a fixed key value into the trigger register. A read is launched simply by reading that register. When a read finishes, the returned word is placed back into the data bytes, where the host can collect it one byte at a time.

The bus side is a simplified AHB-lite-style master. Address, direction, size and write data are presented together with a request flag. They stay frozen until the slave raises its ready input, so slaves may insert any number of wait states. The master has three states. `ST_IDLE` moves to `ST_WR_WAIT` on a write launch, or to `ST_RD_WAIT` on a read launch; a write launch wins if both come in the same cycle. `ST_WR_WAIT` and `ST_RD_WAIT` both return to `ST_IDLE` in the cycle the ready input is sampled high. The read state also loads the captured word into the data registers on that edge. A one-bit enable register gates all launches.

Top module: `byte_bus_bridge`

## Requirements
- R1: After reset, every host register reads 0x00 and the bus request is low.
- R2: Index 0xF0 holds address bits [31:24], 0xF1 bits [23:16], 0xF2 bits [15:8] and 0xF3 bits [7:0]. Each reads back what was written, and together they form the bus address of the next transfer.
- R3: With the bridge enabled and idle, writing 0xCF to index 0xFE issues one bus write to the stored address. The data word is 0xF4..0xF7, with 0xF4 as the most significant byte, and size code 2 gives bus size 2 (4 bytes).
- R4: Writing any value other than 0xCF to index 0xFE launches nothing.
- R5: While bit 0 of index 0x30 is clear, neither a key write nor a read of 0xFE launches a transfer.
- R6: Reading index 0xFE while enabled and idle issues one bus read. After it completes, 0xF4..0xF7 hold the returned word, most significant byte at 0xF4.
- R7: Size code 0 gives a 1-byte access (bus size 0) and code 1 a 2-byte access (bus size 1); any other code gives a 4-byte access. Narrow writes drive only the low bytes of the data word (upper bytes zero). Narrow reads zero-extend the returned low bytes into the data registers.
- R8: The request, address, direction, size and write data stay constant from launch until the cycle ready is sampled high. The request is high for exactly (wait states + 1) cycles.
- R9: Bit 0 of index 0xFE reads 1 from the launch edge until the completion edge, and 0 otherwise.
- R10: A key write or a read of 0xFE that arrives while a transfer is in flight is dropped: no extra transfer follows.
- R11: Bit 0 of index 0x30 is the enable and reads back alone (other bits read 0). Index 0xF8 reads back its full byte. Unmapped indices read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_idx | input | 8 | Host register index |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_rdata | output | 8 | Byte at host_idx (combinational) |
| bus_req | output | 1 | Transfer request, held until bus_ready |
| bus_write | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Transfer address |
| bus_size | output | 3 | Access size, log2 of byte count |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, sampled with bus_ready |
| bus_ready | input | 1 | Slave completes the transfer |

## Verification
The hardest case to reach is a trigger that lands while a transfer is still outstanding. The only way to see the busy flag is to read the trigger register, and that same read is itself a trigger. The bench therefore programs its bus model for a long wait-state run. It launches a write, reads the trigger index to see the busy flag, then sends the key again. It then counts completed bus transfers to show that neither extra trigger started one. A final idle read of the trigger index confirms the flag has cleared and starts exactly one read.

// File: rtl/bbb_pkg.sv
package bbb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_WAIT = 2'd1,
        ST_RD_WAIT = 2'd2
    } mst_state_t;

    localparam logic [7:0] IDX_ENABLE = 8'h30;
    localparam logic [7:0] IDX_ADDR0  = 8'hF0;
    localparam logic [7:0] IDX_DATA0  = 8'hF4;
    localparam logic [7:0] IDX_SIZE   = 8'hF8;
    localparam logic [7:0] IDX_TRIG   = 8'hFE;
    localparam logic [7:0] TRIG_KEY   = 8'hCF;

endpackage

// File: rtl/bbb_regfile.sv
module bbb_regfile
    import bbb_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int DATA_BYTES = 4,
    localparam int AW = 8 * ADDR_BYTES,
    localparam int DW = 8 * DATA_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    idx,
    input  logic [7:0]    wdata,
    input  logic          wr,
    input  logic          busy,
    input  logic          load_rd,
    input  logic [DW-1:0] load_word,
    output logic [7:0]    rdata,
    output logic          en,
    output logic [AW-1:0] addr_word,
    output logic [DW-1:0] data_word,
    output logic [7:0]    size_code
);

    logic [7:0] addr_q [ADDR_BYTES];
    logic [7:0] data_q [DATA_BYTES];
    logic       en_q;
    logic [7:0] size_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            size_q <= '0;
        end else if (wr) begin
            if (idx == IDX_ENABLE) en_q   <= wdata[0];
            if (idx == IDX_SIZE)   size_q <= wdata;
        end
    end

    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_addr
        localparam logic [7:0] SLOT = 8'(IDX_ADDR0 + i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  addr_q[i] <= '0;
            else if (wr && idx == SLOT)  addr_q[i] <= wdata;
        end
        assign addr_word[8*(ADDR_BYTES-1-i) +: 8] = addr_q[i];
    end

    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_data
        localparam logic [7:0] SLOT = 8'(IDX_DATA0 + i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  data_q[i] <= '0;
            else if (load_rd)            data_q[i] <= load_word[8*(DATA_BYTES-1-i) +: 8];
            else if (wr && idx == SLOT)  data_q[i] <= wdata;
        end
        assign data_word[8*(DATA_BYTES-1-i) +: 8] = data_q[i];
    end

    always_comb begin
        rdata = '0;
        if (idx == IDX_ENABLE) rdata = {7'b0, en_q};
        if (idx == IDX_SIZE)   rdata = size_q;
        if (idx == IDX_TRIG)   rdata = {7'b0, busy};
        for (int i = 0; i < ADDR_BYTES; i++)
            if (idx == 8'(IDX_ADDR0 + i)) rdata = addr_q[i];
        for (int i = 0; i < DATA_BYTES; i++)
            if (idx == 8'(IDX_DATA0 + i)) rdata = data_q[i];
    end

    assign en        = en_q;
    assign size_code = size_q;

endmodule

// File: rtl/bbb_trigger.sv
module bbb_trigger
    import bbb_pkg::*;
(
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    input  logic       wr,
    input  logic       rd,
    input  logic       en,
    input  logic       busy,
    output logic       start_wr,
    output logic       start_rd
);

    logic armed;
    logic hit;

    assign armed    = en && !busy;
    assign hit      = (idx == IDX_TRIG);
    assign start_wr = armed && hit && wr && (wdata == TRIG_KEY);
    assign start_rd = armed && hit && rd && !start_wr;

endmodule

// File: rtl/bbb_master.sv
module bbb_master
    import bbb_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int DATA_BYTES = 4,
    localparam int AW = 8 * ADDR_BYTES,
    localparam int DW = 8 * DATA_BYTES,
    localparam int SW = 3,
    localparam logic [SW-1:0] FULL_SIZE = SW'($clog2(DATA_BYTES))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_wr,
    input  logic          start_rd,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic [7:0]    size_in,
    output logic          bus_req,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [SW-1:0] bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    output logic          busy,
    output logic          load_rd,
    output logic [DW-1:0] load_word
);

    mst_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [SW-1:0] size_q;
    logic [SW-1:0] size_enc;
    logic [DW-1:0] lane_mask;
    logic          launch;

    always_comb begin
        unique case (size_in)
            8'd0:    size_enc = SW'(0);
            8'd1:    size_enc = SW'(1);
            default: size_enc = FULL_SIZE;
        endcase
    end

    function automatic logic [DW-1:0] mask_for(input logic [SW-1:0] sz);
        logic [DW-1:0] m;
        m = '0;
        for (int b = 0; b < DATA_BYTES; b++)
            if (b < (1 << sz)) m[8*b +: 8] = 8'hFF;
        return m;
    endfunction

    assign launch    = (state_q == ST_IDLE) && (start_wr || start_rd);
    assign lane_mask = mask_for(size_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_wr)      state_d = ST_WR_WAIT;
                else if (start_rd) state_d = ST_RD_WAIT;
            end
            ST_WR_WAIT: if (bus_ready) state_d = ST_IDLE;
            ST_RD_WAIT: if (bus_ready) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            size_q  <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                addr_q  <= addr_in;
                wdata_q <= data_in & mask_for(size_enc);
                size_q  <= size_enc;
            end
        end
    end

    always_comb begin
        bus_req   = (state_q != ST_IDLE);
        bus_write = (state_q == ST_WR_WAIT);
        bus_addr  = addr_q;
        bus_size  = size_q;
        bus_wdata = wdata_q;
        busy      = (state_q != ST_IDLE);
        load_rd   = (state_q == ST_RD_WAIT) && bus_ready;
        load_word = bus_rdata & lane_mask;
    end

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata)
                                      && $stable(bus_write) && $stable(bus_size)));

    a_r3_write_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !bus_req) |=> (bus_req && bus_write));

    a_r6_read_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start_rd && !start_wr && !bus_req) |=> (bus_req && !bus_write));

    a_r7_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_size <= FULL_SIZE));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready) |=> !bus_req);

endmodule

// File: rtl/byte_bus_bridge.sv
module byte_bus_bridge
    import bbb_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int DATA_BYTES = 4,
    localparam int AW = 8 * ADDR_BYTES,
    localparam int DW = 8 * DATA_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    host_idx,
    input  logic [7:0]    host_wdata,
    input  logic          host_wr,
    input  logic          host_rd,
    output logic [7:0]    host_rdata,
    output logic          bus_req,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [2:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready
);

    logic          en;
    logic          busy;
    logic          start_wr, start_rd;
    logic          load_rd;
    logic [DW-1:0] load_word;
    logic [AW-1:0] addr_word;
    logic [DW-1:0] data_word;
    logic [7:0]    size_code;

    bbb_regfile #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (host_idx),
        .wdata     (host_wdata),
        .wr        (host_wr),
        .busy      (busy),
        .load_rd   (load_rd),
        .load_word (load_word),
        .rdata     (host_rdata),
        .en        (en),
        .addr_word (addr_word),
        .data_word (data_word),
        .size_code (size_code)
    );

    bbb_trigger u_trig (
        .idx      (host_idx),
        .wdata    (host_wdata),
        .wr       (host_wr),
        .rd       (host_rd),
        .en       (en),
        .busy     (busy),
        .start_wr (start_wr),
        .start_rd (start_rd)
    );

    bbb_master #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES)) u_mst (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .addr_in   (addr_word),
        .data_in   (data_word),
        .size_in   (size_code),
        .bus_req   (bus_req),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .busy      (busy),
        .load_rd   (load_rd),
        .load_word (load_word)
    );

    // R5: a disabled, idle bridge never raises a request
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !bus_req) |=> !bus_req);

    // R10: an in-flight transfer never changes direction
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> $stable(bus_write));

    // R9: the busy readback tracks the outstanding request
    a_r9_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (host_idx == IDX_TRIG) |-> (host_rdata[0] == bus_req));

endmodule

// File: tb/test_byte_bus_bridge.sv
module test_byte_bus_bridge;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_idx = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        bus_req, bus_write;
    logic [31:0] bus_addr, bus_wdata;
    logic [2:0]  bus_size;
    logic [31:0] bus_rdata = '0;
    logic        bus_ready = 1'b0;

    int checks = 0;
    int fails = 0;
    int wait_n = 0;
    int wcnt = 0;
    int txn_cnt = 0;
    int req_run = 0;
    int last_len = 0;
    logic [31:0] t_addr, t_wdata;
    logic [2:0]  t_size;
    logic        t_write;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_bus_bridge i_byte_bus_bridge (
        .clk(clk), .rst_n(rst_n),
        .host_idx(host_idx), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    // slave model: ready after wait_n wait states
    always @(negedge clk) begin
        if (!rst_n) begin
            wcnt = 0; bus_ready = 1'b0;
        end else if (bus_req) begin
            if (wcnt >= wait_n) begin bus_ready = 1'b1; wcnt = 0; end
            else begin bus_ready = 1'b0; wcnt = wcnt + 1; end
        end else begin
            bus_ready = 1'b0; wcnt = 0;
        end
    end

    // transfer monitor
    always @(posedge clk) begin
        if (rst_n && bus_req) begin
            if (bus_ready) begin
                txn_cnt  <= txn_cnt + 1;
                last_len <= req_run + 1;
                req_run  <= 0;
                t_addr   <= bus_addr;
                t_wdata  <= bus_wdata;
                t_size   <= bus_size;
                t_write  <= bus_write;
            end else begin
                req_run <= req_run + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        host_idx = idx; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] idx, output logic [7:0] d);
        @(negedge clk);
        host_idx = idx; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_txn(input int target);
        for (int i = 0; i < 200 && txn_cnt < target; i++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 bus_req", {31'b0, bus_req}, 32'h0);
        host_read(8'h30, d); check("R1 enable", {24'b0, d}, 32'h0);
        host_read(8'hF8, d); check("R1 size", {24'b0, d}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            host_read(8'(8'hF0 + i), d); check("R1 addr/data byte", {24'b0, d}, 32'h0);
        end
    endtask

    task automatic t_regs;
        logic [7:0] d;
        host_write(8'hF0, 8'h12); host_write(8'hF1, 8'h34);
        host_write(8'hF2, 8'h56); host_write(8'hF3, 8'h78);
        host_read(8'hF0, d); check("R2 addr byte F0", {24'b0, d}, 32'h12);
        host_read(8'hF3, d); check("R2 addr byte F3", {24'b0, d}, 32'h78);
        host_write(8'h55, 8'hA5);
        host_read(8'h55, d); check("R11 unmapped", {24'b0, d}, 32'h0);
        host_write(8'hF8, 8'h82);
        host_read(8'hF8, d); check("R11 size readback", {24'b0, d}, 32'h82);
        host_write(8'hF8, 8'h02);
    endtask

    task automatic t_disabled;
        logic [7:0] d;
        int base = txn_cnt;
        host_write(8'hFE, 8'hCF);
        host_read(8'hFE, d);
        idle(6);
        check("R5 no transfer while disabled", txn_cnt, base);
        check("R5 request low", {31'b0, bus_req}, 32'h0);
    endtask

    task automatic t_bad_key;
        logic [7:0] d;
        int base;
        host_write(8'h30, 8'hFF);
        host_read(8'h30, d); check("R11 enable bit only", {24'b0, d}, 32'h01);
        base = txn_cnt;
        host_write(8'hFE, 8'h00);
        host_write(8'hFE, 8'hCE);
        idle(6);
        check("R4 wrong key ignored", txn_cnt, base);
    endtask

    task automatic t_write_word;
        int base = txn_cnt;
        wait_n = 0;
        host_write(8'hF4, 8'hDE); host_write(8'hF5, 8'hAD);
        host_write(8'hF6, 8'hBE); host_write(8'hF7, 8'hEF);
        host_write(8'hFE, 8'hCF);
        wait_txn(base + 1);
        idle(1);
        check("R3 one transfer", txn_cnt, base + 1);
        check("R3 direction", {31'b0, t_write}, 32'h1);
        check("R2 address order", t_addr, 32'h12345678);
        check("R3 data order", t_wdata, 32'hDEADBEEF);
        check("R3 size", {29'b0, t_size}, 32'h2);
        check("R8 zero-wait length", last_len, 1);
    endtask

    task automatic t_read_word;
        logic [7:0] d;
        int base = txn_cnt;
        wait_n = 3;
        bus_rdata = 32'hCAFEF00D;
        host_read(8'hFE, d);
        wait_txn(base + 1);
        idle(1);
        check("R6 read direction", {31'b0, t_write}, 32'h0);
        check("R8 request length", last_len, 4);
        host_read(8'hF4, d); check("R6 byte F4", {24'b0, d}, 32'hCA);
        host_read(8'hF5, d); check("R6 byte F5", {24'b0, d}, 32'hFE);
        host_read(8'hF6, d); check("R6 byte F6", {24'b0, d}, 32'hF0);
        host_read(8'hF7, d); check("R6 byte F7", {24'b0, d}, 32'h0D);
    endtask

    task automatic t_sizes;
        logic [7:0] d;
        int base = txn_cnt;
        wait_n = 1;
        host_write(8'hF4, 8'h11); host_write(8'hF5, 8'h22);
        host_write(8'hF6, 8'h33); host_write(8'hF7, 8'h44);
        host_write(8'hF8, 8'h00);
        host_write(8'hFE, 8'hCF);
        wait_txn(base + 1); idle(1);
        check("R7 byte write data", t_wdata, 32'h00000044);
        check("R7 byte size", {29'b0, t_size}, 32'h0);
        host_write(8'hF8, 8'h01);
        host_write(8'hFE, 8'hCF);
        wait_txn(base + 2); idle(1);
        check("R7 half write data", t_wdata, 32'h00003344);
        check("R7 half size", {29'b0, t_size}, 32'h1);
        host_write(8'hF8, 8'h00);
        bus_rdata = 32'hAABBCCDD;
        host_read(8'hFE, d);
        wait_txn(base + 3); idle(1);
        host_read(8'hF4, d); check("R7 narrow read zero-extend F4", {24'b0, d}, 32'h00);
        host_read(8'hF6, d); check("R7 narrow read zero-extend F6", {24'b0, d}, 32'h00);
        host_read(8'hF7, d); check("R7 narrow read low byte", {24'b0, d}, 32'hDD);
        host_write(8'hF8, 8'h02);
    endtask

    task automatic t_busy;
        logic [7:0] d;
        int base = txn_cnt;
        wait_n = 8;
        host_write(8'hFE, 8'hCF);
        host_read(8'hFE, d);
        check("R9 busy while in flight", {24'b0, d}, 32'h01);
        host_write(8'hFE, 8'hCF);
        wait_txn(base + 1);
        idle(12);
        check("R10 dropped triggers", txn_cnt, base + 1);
        check("R10 write kept", {31'b0, t_write}, 32'h1);
        wait_n = 0;
        host_read(8'hFE, d);
        check("R9 idle flag", {24'b0, d}, 32'h00);
        wait_txn(base + 2); idle(2);
        check("R9 idle read launches one read", txn_cnt, base + 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_regs();
        t_disabled();
        t_bad_key();
        t_write_word();
        t_read_word();
        t_sizes();
        t_busy();
        idle(2);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule